// File: doc/BRIEF.md
# Framed Serial Command Receiver

This block takes 32-bit command frames from a three-wire serial port: an active-low frame-select line, a serial clock and a serial data input. All three pins are brought into the system clock domain through synchronizers. Edges are found by comparing each synchronized sample with the one before it. Once a frame is accepted, the block splits out a 4-bit command, a 4-bit address and a 16-bit data word. It announces them to the command logic with a single-cycle strobe. The command logic must take the fields in that cycle, because there is no back-pressure.

The receiver has two modes. In standalone mode a frame is accepted on its 32nd falling serial-clock edge. In chained mode the receiver sits inside a string of devices that share one select line. Bits older than 32 clocks leave on the serial output, so they can feed the next device. The frame is accepted only when select rises, and only if the clock count is a whole number of frames. A frame whose command selects the chain setting switches between the two modes. A frame cut short by select, or by the abort input, produces nothing.

The system clock must run at least four times as fast as the serial clock.

Top module: `frame_cmd_rx`

## Requirements
- R1: Bits arrive most significant first. On acceptance, the command output equals frame bits 27:24, the address output equals bits 23:20 and the data output equals bits 19:4. Bits 31:28 and 3:0 have no effect. The outputs hold their value until the next acceptance.
- R2: A frame opens on a falling edge of the select line. While the frame is open, one data bit is captured on each falling edge of the serial clock.
- R3: In standalone mode the strobe is high for exactly one system cycle, a few cycles after the 32nd falling edge. Further falling edges before select rises produce no second strobe.
- R4: If select rises before the 32nd falling edge, the frame is discarded. There is no strobe and no mode change, and the next frame starts from an empty register.
- R5: Serial clock activity while select is high is ignored.
- R6: The abort input clears the bit count and the shift register. It also blocks any strobe until the next falling edge of select.
- R7: After reset the mode is standalone. An accepted frame with command 8 (binary 1000) sets chained mode from data bit 1, which is frame bit 5: 1 selects chained mode and 0 selects standalone mode.
- R8: In chained mode, once 32 bits have been shifted in, the serial output changes after each rising serial-clock edge. It shows the bit received 32 falling edges earlier, so the value is ready for the next falling edge.
- R9: In chained mode nothing is accepted on a falling edge. When select rises, the last 32 bits are accepted only if the number of falling edges is a non-zero multiple of 32. Any other count is discarded.
- R10: In standalone mode the serial output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Frame select from the serial port, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| sdi_i | input | 1 | Serial data in |
| abort_i | input | 1 | Abort request for the current frame (system domain) |
| sdo_o | output | 1 | Serial data out toward the next device in a chain |
| frm_valid_o | output | 1 | One-cycle strobe marking an accepted frame |
| frm_cmd_o | output | 4 | Command field of the last accepted frame |
| frm_addr_o | output | 4 | Address field of the last accepted frame |
| frm_data_o | output | 16 | Data field of the last accepted frame |

## Verification
The bench builds the block with its default parameters: a 32-bit frame and two synchronizer stages. It runs the system clock sixteen times faster than the serial clock. At that ratio, each change on the serial output has settled before the next falling edge, so the bench can compare the output bit by bit against the frame sent 32 clocks earlier. With one frame length, both 64-bit two-frame chains and the bad 48-clock count are within reach. Short frames, aborted frames and extra clocks are each followed by a frame that must decode exactly.

// File: rtl/frx_pkg.sv
package frx_pkg;
  localparam int FRAME_W   = 32;
  localparam int CMD_W     = 4;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 16;
  localparam int CMD_LSB   = 24;
  localparam int ADDR_LSB  = 20;
  localparam int DATA_LSB  = 4;
  localparam int CHAIN_BIT = 1;
  localparam logic [CMD_W-1:0] CMD_CHAIN = 4'h8;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frx_frame_t;

  function automatic frx_frame_t frx_split(input logic [FRAME_W-1:0] w);
    frx_frame_t f;
    f.cmd  = w[CMD_LSB  +: CMD_W];
    f.addr = w[ADDR_LSB +: ADDR_W];
    f.data = w[DATA_LSB +: DATA_W];
    return f;
  endfunction
endpackage

// File: rtl/frx_sync.sv
module frx_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/frx_edge.sv
module frx_edge #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= cur;
  end

  assign rise = ~prev & cur;
  assign fall = prev & ~cur;
endmodule

// File: rtl/frx_shift.sv
module frx_shift #(
  parameter int BITS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            shift_en,
  input  logic            bit_in,
  input  logic            drive_en,
  input  logic            chain_en,
  output logic [BITS-1:0] word,
  output logic            sdo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (clr)      word <= '0;
    else if (shift_en) word <= {word[BITS-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sdo <= 1'b0;
    else if (!chain_en) sdo <= 1'b0;
    else if (drive_en)  sdo <= word[BITS-1];
  end
endmodule

// File: rtl/frx_ctrl.sv
module frx_ctrl #(
  parameter int BITS = 32,
  localparam int CNT_W = $clog2(BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_fall,
  input  logic             sel_rise,
  input  logic             sclk_fall,
  input  logic             sclk_rise,
  input  logic             abort,
  input  logic             chain_hit,
  input  logic             chain_val,
  output logic             shift_en,
  output logic             clr,
  output logic             commit,
  output logic             commit_now,
  output logic             drive_en,
  output logic             chain_en,
  output logic             act,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

  logic full_q;
  logic commit_chain;

  assign clr          = abort | sel_fall | sel_rise;
  assign shift_en     = act & sclk_fall & ~clr;
  assign commit_now   = shift_en & ~chain_en & (cnt == LAST);
  assign commit_chain = act & chain_en & sel_rise & ~abort & full_q & (cnt == '0);
  assign commit       = commit_now | commit_chain;
  assign drive_en     = act & chain_en & sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= 1'b0;
      cnt    <= '0;
      full_q <= 1'b0;
    end else begin
      if (abort)                        act <= 1'b0;
      else if (sel_fall)                act <= 1'b1;
      else if (sel_rise || commit_now)  act <= 1'b0;

      if (clr) begin
        cnt    <= '0;
        full_q <= 1'b0;
      end else if (shift_en) begin
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        if (cnt == LAST) full_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     chain_en <= 1'b0;
    else if (commit && chain_hit)   chain_en <= chain_val;
  end
endmodule

// File: rtl/frame_cmd_rx.sv
module frame_cmd_rx
  import frx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              abort_i,
  output logic              sdo_o,
  output logic              frm_valid_o,
  output logic [CMD_W-1:0]  frm_cmd_o,
  output logic [ADDR_W-1:0] frm_addr_o,
  output logic [DATA_W-1:0] frm_data_o
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic [2:0]         pins_s;
  logic [1:0]         rise_e, fall_e;
  logic               sel_fall, sel_rise, sclk_fall, sclk_rise;
  logic               shift_en, clr, commit, commit_now, drive_en;
  logic               chain_en, frame_act;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shreg, commit_word;
  frx_frame_t         cw, out_q;
  logic               valid_q;
  logic               unused_bits;

  frx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sdi_i, sclk_i, sel_n_i}), .q(pins_s)
  );

  frx_edge #(.WIDTH(2), .RST_VAL(2'b11)) u_edge (
    .clk(clk), .rst_n(rst_n), .cur(pins_s[1:0]), .rise(rise_e), .fall(fall_e)
  );

  assign sel_fall  = fall_e[0];
  assign sel_rise  = rise_e[0];
  assign sclk_fall = fall_e[1];
  assign sclk_rise = rise_e[1];

  frx_shift #(.BITS(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(shift_en), .bit_in(pins_s[2]),
    .drive_en(drive_en), .chain_en(chain_en), .word(shreg), .sdo(sdo_o)
  );

  assign commit_word = commit_now ? {shreg[FRAME_W-2:0], pins_s[2]} : shreg;
  assign cw          = frx_split(commit_word);
  assign unused_bits = ^{commit_word[FRAME_W-1:CMD_LSB+CMD_W], commit_word[DATA_LSB-1:0]};

  frx_ctrl #(.BITS(FRAME_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_fall(sel_fall), .sel_rise(sel_rise),
    .sclk_fall(sclk_fall), .sclk_rise(sclk_rise), .abort(abort_i),
    .chain_hit(cw.cmd == CMD_CHAIN), .chain_val(cw.data[CHAIN_BIT]),
    .shift_en(shift_en), .clr(clr), .commit(commit), .commit_now(commit_now),
    .drive_en(drive_en), .chain_en(chain_en), .act(frame_act), .cnt(bit_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      out_q   <= '0;
    end else begin
      valid_q <= commit;
      if (commit) out_q <= cw;
    end
  end

  assign frm_valid_o = valid_q;
  assign frm_cmd_o   = out_q.cmd;
  assign frm_addr_o  = out_q.addr;
  assign frm_data_o  = out_q.data;
endmodule

// File: rtl/frx_chk.sv
module frx_chk #(
  parameter int CNT_W = 5,
  parameter int DW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid,
  input logic [DW-1:0]    frm_data,
  input logic             sdo,
  input logic             chain,
  input logic             act,
  input logic [CNT_W-1:0] cnt,
  input logic             abort,
  input logic             sel_rise
);
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> (frm_valid || $stable(frm_data))); // R1

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid); // R3

  AST_STROBE_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> $past(act)); // R2

  AST_SEL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise |=> !act); // R4

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!act && cnt == '0)); // R6

  AST_CHAIN_AT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && $past(chain)) |-> $past(sel_rise)); // R9

  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !chain |=> !sdo); // R10
endmodule

bind frame_cmd_rx frx_chk #(.CNT_W(CNT_W), .DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid_o), .frm_data(frm_data_o),
  .sdo(sdo_o), .chain(chain_en), .act(frame_act), .cnt(bit_cnt),
  .abort(abort_i), .sel_rise(sel_rise)
);

// File: tb/tb_frame_cmd_rx.sv
module tb_frame_cmd_rx;
  localparam int CLK_P = 10;
  localparam int SCK_H = 80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b1, sdi = 1'b0, abort = 1'b0;
  logic sdo, frm_valid;
  logic [3:0] frm_cmd, frm_addr;
  logic [15:0] frm_data;

  int checks = 0, failures = 0, strobes = 0;
  bit done = 1'b0;
  logic [23:0] exp_q[$];
  logic prev_valid = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  frame_cmd_rx dut (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sclk_i(sclk), .sdi_i(sdi),
    .abort_i(abort), .sdo_o(sdo), .frm_valid_o(frm_valid), .frm_cmd_o(frm_cmd),
    .frm_addr_o(frm_addr), .frm_data_o(frm_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkw(input logic [3:0] top, input logic [3:0] c, input logic [3:0] a,
                                      input logic [15:0] d, input logic [3:0] lo);
    return {top, c, a, d, lo};
  endfunction

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (rst_n && frm_valid) begin
      strobes++;
      if (exp_q.size() == 0) check(1'b0, "R4 unexpected strobe", {frm_cmd, frm_addr, frm_data}, 0);
      else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        check({frm_cmd, frm_addr, frm_data} == e, "R1 fields", {frm_cmd, frm_addr, frm_data}, e);
      end
      if (prev_valid) check(1'b0, "R3 strobe longer than one cycle", 1, 0);
    end
    prev_valid = frm_valid;
  end

  // mode: 0 no sdo check, 1 chained (delayed copy), 2 must stay low
  task automatic shift_bits(input logic [63:0] v, input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      sdi = v[n-1-i];
      #(SCK_H);
      if (mode == 1 && i >= 32) check(sdo == v[n-1-(i-32)], "R8 sdo", sdo, v[n-1-(i-32)]);
      if (mode == 2) check(sdo == 1'b0, "R10 sdo low", sdo, 0);
      sclk = 1'b0;
      #(SCK_H);
      sclk = 1'b1;
    end
  endtask

  task automatic open_frame();
    sel_n = 1'b0;
    #(SCK_H);
  endtask

  task automatic close_frame();
    #(SCK_H);
    sel_n = 1'b1;
    #(6*SCK_H);
  endtask

  task automatic expect_frame(input logic [31:0] w);
    exp_q.push_back(w[27:4]);
  endtask

  initial begin
    int s0;
    logic [31:0] w1, w2;
    #(5*CLK_P + 3);
    check(frm_valid == 1'b0, "R3 reset strobe low", frm_valid, 0);
    check(sdo == 1'b0, "R10 reset sdo low", sdo, 0);
    check({frm_cmd, frm_addr, frm_data} == 24'h0, "R1 reset fields", {frm_cmd, frm_addr, frm_data}, 0);
    rst_n = 1'b1;
    #(10*CLK_P);

    // R1 R2: plain standalone frame, ignored bits set
    w1 = mkw(4'hF, 4'h3, 4'h1, 16'hBEEF, 4'hA);
    expect_frame(w1);
    open_frame(); shift_bits({32'h0, w1}, 32, 2); close_frame();

    // R3: extra clocks after the 32nd edge with select still low
    w1 = mkw(4'h0, 4'h5, 4'h2, 16'h1234, 4'h0);
    expect_frame(w1);
    s0 = strobes;
    open_frame(); shift_bits({24'h0, w1, 8'hFF}, 40, 2);
    #(10*CLK_P);
    check(strobes == s0 + 1, "R3 single commit before select rise", strobes - s0, 1);
    close_frame();
    check(strobes == s0 + 1, "R3 no second strobe", strobes - s0, 1);

    // R4: chain-enable frame cut short
    s0 = strobes;
    w1 = mkw(4'h0, 4'h8, 4'h0, 16'h0002, 4'h0);
    open_frame(); shift_bits({32'h0, w1}, 20, 0); close_frame();
    check(strobes == s0, "R4 short frame discarded", strobes - s0, 0);
    w1 = mkw(4'h3, 4'h6, 4'h7, 16'h0F0F, 4'h5);
    expect_frame(w1);
    open_frame(); shift_bits({32'h0, w1}, 32, 2);
    #(10*CLK_P);
    check(strobes == s0 + 1, "R4 mode unchanged, commit on 32nd edge", strobes - s0, 1);
    close_frame();

    // R5: clocks while select high
    s0 = strobes;
    shift_bits(64'hFFFF_0000_FFFF_0000, 40, 0);
    #(6*SCK_H);
    check(strobes == s0, "R5 clocks with select high ignored", strobes - s0, 0);
    w1 = mkw(4'h0, 4'h2, 4'h9, 16'h8001, 4'h0);
    expect_frame(w1);
    open_frame(); shift_bits({32'h0, w1}, 32, 0); close_frame();

    // R6: abort in the middle, then more clocks with select still low
    s0 = strobes;
    open_frame(); shift_bits(64'h0000_0000_0000_03FF, 10, 0);
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    shift_bits(64'h0000_00FF_FFFF_FFFF, 40, 0); close_frame();
    check(strobes == s0, "R6 aborted frame suppressed", strobes - s0, 0);
    w1 = mkw(4'h0, 4'hC, 4'h4, 16'h7E7E, 4'h0);
    expect_frame(w1);
    open_frame(); shift_bits({32'h0, w1}, 32, 0); close_frame();

    // R7: enter chained mode
    w1 = mkw(4'h0, 4'h8, 4'h0, 16'h0002, 4'h0);
    expect_frame(w1);
    open_frame(); shift_bits({32'h0, w1}, 32, 0); close_frame();

    // R8 R9: two frames through the chain
    w1 = mkw(4'h1, 4'h2, 4'h3, 16'h1111, 4'h0);
    w2 = mkw(4'h0, 4'h4, 4'h1, 16'hABCD, 4'h5);
    expect_frame(w2);
    s0 = strobes;
    open_frame(); shift_bits({w1, w2}, 64, 1);
    #(10*CLK_P);
    check(strobes == s0, "R9 no commit on falling edge in chain mode", strobes - s0, 0);
    close_frame();
    check(strobes == s0 + 1, "R9 commit at select rise", strobes - s0, 1);

    // R9: count not a multiple of 32
    s0 = strobes;
    open_frame(); shift_bits({16'h0, mkw(4'h0, 4'h4, 4'h0, 16'h5555, 4'h0)}, 48, 0); close_frame();
    check(strobes == s0, "R9 48 clocks discarded", strobes - s0, 0);

    // R9: exactly 32 in chain mode
    w1 = mkw(4'h0, 4'h6, 4'h0, 16'h5A5A, 4'h0);
    expect_frame(w1);
    s0 = strobes;
    open_frame(); shift_bits({32'h0, w1}, 32, 0);
    #(10*CLK_P);
    check(strobes == s0, "R9 held until select rise", strobes - s0, 0);
    close_frame();
    check(strobes == s0 + 1, "R9 single frame committed", strobes - s0, 1);

    // R7: leave chained mode, then standalone timing and quiet output
    w1 = mkw(4'h0, 4'h8, 4'h0, 16'h0000, 4'h0);
    expect_frame(w1);
    open_frame(); shift_bits({32'h0, w1}, 32, 0); close_frame();
    w1 = mkw(4'h9, 4'h1, 4'hE, 16'hC3C3, 4'hF);
    expect_frame(w1);
    s0 = strobes;
    open_frame(); shift_bits({32'h0, w1}, 32, 2);
    #(10*CLK_P);
    check(strobes == s0 + 1, "R7 back in standalone, commit on 32nd edge", strobes - s0, 1);
    close_frame();

    check(exp_q.size() == 0, "R1 all expected frames seen", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule